// File: doc/BRIEF.md
# Raster-Scheduled Shared RAM Slot Arbiter

This block shares one word-wide RAM among three masters: a processor, a display fetch engine and an audio sample fetcher. Ownership is not decided by comparing requests. It is fixed by the position of the raster beam. A video timing generator pulses `line_start` once per scan line and reports whether that line is a visible one. The arbiter cuts the line into memory slots of `SLOT_CLKS` clocks each. A line holds two slots per word time, with `ACT_WORDS` visible word times followed by `BLK_WORDS` blanking word times.

On a visible line, the processor and the display engine take turns slot by slot across the visible span. The very last slot of every line, visible or not, carries one audio fetch, and it occupies the position the display engine would hold. Every remaining slot belongs to the processor. With the defaults, the processor receives 55 of the 88 slots on a visible line and 87 of 88 on a blanking line. The processor side uses a level request with a one-clock acknowledge and a wait flag. The arbiter also drives the select line that steers the RAM address multiplexer toward the DMA address sources.

Top module: `ram_slot_arb`

## Requirements
- R1: From reset until the first `line_start` pulse has been clocked in, `owner` is 0 and no grant is asserted.
- R2: The slot index counts from 0 at the start of a line. On a visible line, slots 0 to 2*ACT_WORDS-1 alternate: even slots go to the processor and odd slots go to video.
- R3: The last slot of the line (index 2*(ACT_WORDS+BLK_WORDS)-1) goes to sound when audio was enabled at that line's `line_start`. Otherwise it goes to the processor.
- R4: Every other slot goes to the processor. This covers the horizontal blanking slots and every slot of a line marked not visible, except the sound slot.
- R5: `owner` encodes 0 = none, 1 = processor, 2 = video, 3 = sound. Once synchronised, exactly one of `gnt_cpu`, `gnt_vid`, `gnt_snd` is high, and it is the one that matches `owner`.
- R6: A grant holds for all `SLOT_CLKS` clocks of its slot. It changes only at a slot boundary or after a `line_start`.
- R7: A `line_start` seen at a clock edge makes the next clock the first clock of slot 0, even if it arrives mid-line or mid-slot. Without a pulse, the index wraps from the last slot to slot 0 by itself.
- R8: `cpu_ack` is high exactly in the last clock of a processor slot while `cpu_req` is high. `cpu_wait` equals `cpu_req` and not `cpu_ack`. A request raised during a video or sound slot is therefore held until the next processor slot ends.
- R9: `dma_sel` is 1 in video and sound slots and 0 otherwise.
- R10: `active_line` and `snd_en` are captured only at `line_start`. Changing them mid-line has no effect on that line's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-clock pulse marking the start of a scan line |
| active_line | input | 1 | The line starting now is a visible line |
| snd_en | input | 1 | Audio fetch enabled for the line starting now |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| owner | output | 2 | Current slot owner code |
| gnt_cpu | output | 1 | Processor owns the slot |
| gnt_vid | output | 1 | Video fetch owns the slot |
| gnt_snd | output | 1 | Sound fetch owns the slot |
| dma_sel | output | 1 | RAM address mux selects the DMA address |
| cpu_ack | output | 1 | Processor access completes this clock |
| cpu_wait | output | 1 | Processor must stall |

## Verification
Two functions can fall in the same clock: the processor handshake and the slot rotation. A pending request can be acknowledged only in the closing clock of a processor slot. The bench raises `cpu_req` while the display engine owns the slot. It expects `cpu_wait` through that slot and the first clock of the next processor slot, then `cpu_ack` exactly in that slot's second clock. In parallel, a scoreboard checks every clock's owner, grants and mux select against a pattern computed from the slot index, including mid-slot restarts and free-running wraps.

// File: rtl/ram_slot_arb_pkg.sv
package ram_slot_arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_VID  = 2'd2,
      OWN_SND  = 2'd3
   } owner_t;
endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
   parameter int SLOT_CLKS  = 2,
   parameter int LINE_SLOTS = 88,
   parameter int IDX_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             active_line,
   input  logic             snd_en,
   output logic             synced,
   output logic             vact,
   output logic             snd_q,
   output logic [IDX_W-1:0] idx,
   output logic             slot_end
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_SLOTS - 1);

   generate
      if (SLOT_CLKS > 1) begin : g_multi
         localparam int SUB_W = $clog2(SLOT_CLKS);
         localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_CLKS - 1);
         logic [SUB_W-1:0] sub;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           sub <= '0;
            else if (line_start)  sub <= '0;
            else if (sub == SUB_LAST) sub <= '0;
            else                  sub <= sub + 1'b1;
         end
         assign slot_end = (sub == SUB_LAST);
      end else begin : g_single
         assign slot_end = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced <= 1'b0;
         vact   <= 1'b0;
         snd_q  <= 1'b0;
         idx    <= '0;
      end else if (line_start) begin
         synced <= 1'b1;
         vact   <= active_line;
         snd_q  <= snd_en;
         idx    <= '0;
      end else if (slot_end) begin
         idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
   end
endmodule

// File: rtl/arb_slot_decode.sv
module arb_slot_decode
   import ram_slot_arb_pkg::*;
#(
   parameter int ACT_SLOTS  = 64,
   parameter int LINE_SLOTS = 88,
   parameter int IDX_W      = 7
) (
   input  logic             synced,
   input  logic             vact,
   input  logic             snd_q,
   input  logic [IDX_W-1:0] idx,
   output owner_t           owner
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_SLOTS - 1);
   localparam logic [IDX_W-1:0] ACT_LIM  = IDX_W'(ACT_SLOTS);

   always_comb begin
      if (!synced)
         owner = OWN_NONE;
      else if (idx == LAST_IDX && snd_q)
         owner = OWN_SND;
      else if (vact && idx < ACT_LIM && idx[0])
         owner = OWN_VID;
      else
         owner = OWN_CPU;
   end
endmodule

// File: rtl/arb_cpu_hs.sv
module arb_cpu_hs
   import ram_slot_arb_pkg::*;
(
   input  logic   cpu_req,
   input  owner_t owner,
   input  logic   slot_end,
   output logic   cpu_ack,
   output logic   cpu_wait
);
   always_comb begin
      cpu_ack  = cpu_req && (owner == OWN_CPU) && slot_end;
      cpu_wait = cpu_req && !cpu_ack;
   end
endmodule

// File: rtl/ram_slot_arb.sv
module ram_slot_arb
   import ram_slot_arb_pkg::*;
#(
   parameter int SLOT_CLKS = 2,
   parameter int ACT_WORDS = 32,
   parameter int BLK_WORDS = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_start,
   input  logic       active_line,
   input  logic       snd_en,
   input  logic       cpu_req,
   output logic [1:0] owner,
   output logic       gnt_cpu,
   output logic       gnt_vid,
   output logic       gnt_snd,
   output logic       dma_sel,
   output logic       cpu_ack,
   output logic       cpu_wait
);
   localparam int ACT_SLOTS  = 2 * ACT_WORDS;
   localparam int LINE_SLOTS = 2 * (ACT_WORDS + BLK_WORDS);
   localparam int IDX_W      = $clog2(LINE_SLOTS);

   generate
      if (SLOT_CLKS < 1) begin : g_bad_slot
         $error("SLOT_CLKS must be at least 1");
      end
      if (ACT_WORDS < 1) begin : g_bad_act
         $error("ACT_WORDS must be at least 1");
      end
      if (BLK_WORDS < 1) begin : g_bad_blk
         $error("BLK_WORDS must be at least 1 so the sound slot lies in blanking");
      end
   endgenerate

   logic             synced, vact, snd_q, slot_end;
   logic [IDX_W-1:0] idx;
   owner_t           own;

   arb_slot_timer #(
      .SLOT_CLKS (SLOT_CLKS),
      .LINE_SLOTS(LINE_SLOTS),
      .IDX_W     (IDX_W)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .active_line(active_line),
      .snd_en     (snd_en),
      .synced     (synced),
      .vact       (vact),
      .snd_q      (snd_q),
      .idx        (idx),
      .slot_end   (slot_end)
   );

   arb_slot_decode #(
      .ACT_SLOTS (ACT_SLOTS),
      .LINE_SLOTS(LINE_SLOTS),
      .IDX_W     (IDX_W)
   ) decode_i (
      .synced(synced),
      .vact  (vact),
      .snd_q (snd_q),
      .idx   (idx),
      .owner (own)
   );

   arb_cpu_hs hs_i (
      .cpu_req (cpu_req),
      .owner   (own),
      .slot_end(slot_end),
      .cpu_ack (cpu_ack),
      .cpu_wait(cpu_wait)
   );

   assign owner   = own;
   assign gnt_cpu = (own == OWN_CPU);
   assign gnt_vid = (own == OWN_VID);
   assign gnt_snd = (own == OWN_SND);
   assign dma_sel = own[1];
endmodule

// File: rtl/ram_slot_arb_chk.sv
module ram_slot_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       line_start,
   input logic       cpu_req,
   input logic       slot_end,
   input logic [1:0] owner,
   input logic       gnt_cpu,
   input logic       gnt_vid,
   input logic       gnt_snd,
   input logic       dma_sel,
   input logic       cpu_ack,
   input logic       cpu_wait
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen <= 1'b0;
      else if (line_start) seen <= 1'b1;
   end

   AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (owner == 2'd0 && !gnt_cpu && !gnt_vid && !gnt_snd)); // R1

   AST_SND_THEN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_snd && slot_end) |=> gnt_cpu); // R3

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_cpu, gnt_vid, gnt_snd})); // R5

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != 2'd0) |-> ($countones({gnt_cpu, gnt_vid, gnt_snd}) == 1)); // R5

   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && !slot_end) |=> $stable(owner)); // R6

   AST_ACK_IN_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> (gnt_cpu && cpu_req && slot_end)); // R8

   AST_WAIT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_ack) |-> cpu_wait); // R8

   AST_IDLE_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> (!cpu_wait && !cpu_ack)); // R8

   AST_DMA_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      dma_sel == (gnt_vid || gnt_snd)); // R9
endmodule

bind ram_slot_arb ram_slot_arb_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_start(line_start),
   .cpu_req   (cpu_req),
   .slot_end  (slot_end),
   .owner     (owner),
   .gnt_cpu   (gnt_cpu),
   .gnt_vid   (gnt_vid),
   .gnt_snd   (gnt_snd),
   .dma_sel   (dma_sel),
   .cpu_ack   (cpu_ack),
   .cpu_wait  (cpu_wait)
);

// File: tb/ram_slot_arb_tb_top.sv
module ram_slot_arb_tb_top;
   localparam int SLOT_CLKS  = 2;
   localparam int ACT_WORDS  = 32;
   localparam int BLK_WORDS  = 12;
   localparam int ACT_SLOTS  = 2 * ACT_WORDS;
   localparam int LINE_SLOTS = 2 * (ACT_WORDS + BLK_WORDS);
   localparam int LINE_CLKS  = LINE_SLOTS * SLOT_CLKS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic       active_line = 1'b0;
   logic       snd_en = 1'b0;
   logic       cpu_req = 1'b0;
   logic [1:0] owner;
   logic       gnt_cpu, gnt_vid, gnt_snd, dma_sel, cpu_ack, cpu_wait;

   int checks = 0;
   int failures = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   ram_slot_arb #(
      .SLOT_CLKS(SLOT_CLKS),
      .ACT_WORDS(ACT_WORDS),
      .BLK_WORDS(BLK_WORDS)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .active_line(active_line),
      .snd_en     (snd_en),
      .cpu_req    (cpu_req),
      .owner      (owner),
      .gnt_cpu    (gnt_cpu),
      .gnt_vid    (gnt_vid),
      .gnt_snd    (gnt_snd),
      .dma_sel    (dma_sel),
      .cpu_ack    (cpu_ack),
      .cpu_wait   (cpu_wait)
   );

   // Expected owner for clock k of a line (R2, R3, R4)
   function automatic int exp_owner(int k, bit act, bit snd);
      int s = k / SLOT_CLKS;
      if (s == LINE_SLOTS - 1 && snd) return 3;
      if (act && s < ACT_SLOTS && (s % 2) == 1) return 2;
      return 1;
   endfunction

   task automatic check(bit ok, string req, int act_v, int exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
      end
   endtask

   // Monitor: pops one expected owner per clock and compares grants (R5, R6, R9)
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         int e;
         e = exp_q.pop_front();
         check(owner == 2'(e), "R2/R3/R4/R7 owner", owner, e);
         check({gnt_snd, gnt_vid, gnt_cpu} == (3'b1 << (e - 1)), "R5 grants",
               {gnt_snd, gnt_vid, gnt_cpu}, 3'b1 << (e - 1));
         check(dma_sel == (e >= 2), "R9 dma_sel", dma_sel, e >= 2);
      end
   end

   // Driver: called at a negedge; pulses line_start and queues nclk expected owners
   task automatic run_line(bit act, bit snd, bit flip, int nclk);
      line_start  = 1'b1;
      active_line = act;
      snd_en      = snd;
      @(posedge clk);
      #1;
      for (int k = 0; k < nclk; k++) exp_q.push_back(exp_owner(k, act, snd));
      @(negedge clk);
      line_start = 1'b0;
      if (flip) begin   // R10: mid-line changes must be ignored
         active_line = ~act;
         snd_en      = ~snd;
      end
      repeat (nclk - 1) @(negedge clk);
   endtask

   // Free-running wrap with no line_start pulse (R7)
   task automatic free_line(bit act, bit snd);
      @(posedge clk);
      #1;
      for (int k = 0; k < LINE_CLKS; k++) exp_q.push_back(exp_owner(k, act, snd));
      repeat (LINE_CLKS) @(negedge clk);
   endtask

   // Processor request raised in a video slot (R8)
   task automatic cpu_probe();
      repeat (3) @(negedge clk);     // slot 1 (video), first clock
      cpu_req = 1'b1;
      #1;
      check(cpu_wait && !cpu_ack, "R8 wait in video slot clk0", {cpu_wait, cpu_ack}, 2'b10);
      @(negedge clk);
      check(cpu_wait && !cpu_ack, "R8 wait in video slot clk1", {cpu_wait, cpu_ack}, 2'b10);
      @(negedge clk);                // slot 2 (processor), first clock
      check(cpu_wait && !cpu_ack, "R8 wait cpu slot clk0", {cpu_wait, cpu_ack}, 2'b10);
      @(negedge clk);                // slot 2, last clock
      check(!cpu_wait && cpu_ack, "R8 ack cpu slot end", {cpu_wait, cpu_ack}, 2'b01);
      #2 cpu_req = 1'b0;
      @(negedge clk);
      check(!cpu_wait && !cpu_ack, "R8 idle after ack", {cpu_wait, cpu_ack}, 2'b00);
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: no grant before the first line start
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(owner == 2'd0 && !gnt_cpu && !gnt_vid && !gnt_snd && !dma_sel,
               "R1 idle before sync", owner, 0);
      end
      cpu_req = 1'b1;
      #1 check(cpu_wait && !cpu_ack, "R1/R8 no ack before sync", cpu_ack, 0);
      cpu_req = 1'b0;
      @(negedge clk);
      fork
         run_line(1'b1, 1'b1, 1'b0, LINE_CLKS);
         cpu_probe();
      join
      run_line(1'b1, 1'b0, 1'b0, LINE_CLKS);   // R3 sound disabled
      run_line(1'b0, 1'b1, 1'b0, LINE_CLKS);   // R4 blanking line
      run_line(1'b0, 1'b0, 1'b0, LINE_CLKS);   // R4 all processor
      run_line(1'b1, 1'b1, 1'b1, LINE_CLKS);   // R10 flip mid-line
      run_line(1'b1, 1'b1, 1'b0, 37);          // R7 restart mid-slot
      run_line(1'b1, 1'b1, 1'b0, LINE_CLKS);
      free_line(1'b1, 1'b1);                   // R7 wrap without pulse
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule